// File: doc/BRIEF.md
# Pseudo-Random Light Intensity Modulator

This block drives a single light pin from a slow clock (typically 32 kHz) using a pseudo-random pulse pattern instead of a counter-based ramp. An 8-bit maximal-length linear feedback shift register runs freely and steps through all 255 nonzero states. Each cycle its value is compared with a programmed brightness level. The pin is high whenever the register value is strictly below the level.

The on-time therefore spreads across the 255-cycle period instead of sitting in one block. This pushes the energy of the waveform to higher frequencies at the same average duty. The pattern repeats every 255 clocks, and the duty moves in steps of 1/255.

The shift register holds no zero state. Levels 0 and 1 therefore both give a dark output. The top level, 255, gives 254/255 rather than a constant high.

Top module: `lfsr_light_pwm`

## Requirements
- R1: The sequence register is a Fibonacci LFSR for x^8+x^6+x^5+x^4+1. Its next value is {q[6:0], q[7]^q[5]^q[4]^q[3]}. It loads 8'h01 on reset and returns to any given value after exactly 255 clocks.
- R2: The sequence register never holds 0. If 0 is ever detected, the next value is 8'h01.
- R3: light_o is registered. After a clock edge it equals en_i AND (sequence value < level), with both operands taken as they stood before that edge. It is 0 during reset.
- R4: With level 0 or level 1, light_o stays low for every cycle.
- R5: With level 2, light_o is high for exactly one cycle in any 255 consecutive cycles.
- R6: With level 255, light_o is high for exactly 254 of any 255 consecutive cycles.
- R7: For any level L in the range 1 to 255, light_o is high for exactly L-1 of any 255 consecutive enabled cycles.
- R8: While en_i is 0, light_o is held low. The sequence register keeps advancing regardless of en_i.
- R9: The level resets to 0. When lvl_we_i is 1 at a clock edge, lvl_data_i is loaded, and it is used in the comparison from the following edge on. When lvl_we_i is 0, the level holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slow modulation clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Output enable; low forces the pin dark |
| lvl_we_i | input | 1 | Level write strobe |
| lvl_data_i | input | 8 | New brightness level |
| light_o | output | 1 | Modulated light drive |

## Verification
The bench builds the block with its default 8-bit width and the x^8+x^6+x^5+x^4+1 tap mask. At this width one full period is only 255 clocks, so every one of the 256 level codes can be swept. A full-window high count is checked against L-1 for each code. A cycle-accurate model of the register and comparator tracks every cycle, including random enable toggling and level writes made while dark. This shows that the sequence keeps running behind a disabled output.

// File: rtl/lfsr_light_pwm_pkg.sv
package lfsr_light_pwm_pkg;
  localparam int unsigned DEF_W    = 8;
  // x^8+x^6+x^5+x^4+1 -> feedback from bits 7,5,4,3
  localparam logic [DEF_W-1:0] DEF_TAPS = 8'hB8;
  localparam logic [DEF_W-1:0] DEF_SEED = 8'h01;
endpackage

// File: rtl/lpwm_lfsr.sv
module lpwm_lfsr #(
  parameter int unsigned    W    = 8,
  parameter logic [W-1:0]   TAPS = 8'hB8,
  parameter logic [W-1:0]   SEED = 8'h01
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] q_o
);
  localparam int unsigned PERIOD = (1 << W) - 1;

  logic [W-1:0] q_q, q_d;
  logic         fb;

  assign fb = ^(q_q & TAPS);

  generate
    if (W > 1) begin : g_shift
      // zero-state guard reloads seed
      assign q_d = (q_q == '0) ? SEED : {q_q[W-2:0], fb};
    end else begin : g_single
      assign q_d = (q_q == '0) ? SEED : fb;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= SEED;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  // period checker
  logic [W:0] per_cnt_q;
  logic       seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_cnt_q <= '0;
      seen_q    <= 1'b0;
    end else if (q_q == SEED) begin
      per_cnt_q <= 1;
      seen_q    <= 1'b1;
    end else begin
      per_cnt_q <= per_cnt_q + 1'b1;
    end
  end

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q != '0);

  // R1
  lfsr_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q == SEED && seen_q) |-> per_cnt_q == PERIOD);
endmodule

// File: rtl/lpwm_level_reg.sv
module lpwm_level_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] level_o
);
  logic [W-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   level_q <= '0;
    else if (we_i) level_q <= data_i;
  end

  assign level_o = level_q;

  // R9
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(level_q));

  // R9
  level_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> level_q == $past(data_i));
endmodule

// File: rtl/lpwm_cmp_out.sv
module lpwm_cmp_out #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] seq_i,
  input  logic [W-1:0] level_i,
  output logic         light_o
);
  logic light_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) light_q <= 1'b0;
    else         light_q <= en_i && (seq_i < level_i);
  end

  assign light_o = light_q;

  // R8
  dark_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !light_q);

  // R4
  low_levels_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i <= 1) |=> !light_q);

  // R6
  full_level_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && level_i == '1 && seq_i != '1) |=> light_q);
endmodule

// File: rtl/lfsr_light_pwm.sv
module lfsr_light_pwm
  import lfsr_light_pwm_pkg::*;
#(
  parameter int unsigned  W    = DEF_W,
  parameter logic [W-1:0] TAPS = DEF_TAPS,
  parameter logic [W-1:0] SEED = DEF_SEED
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         lvl_we_i,
  input  logic [W-1:0] lvl_data_i,
  output logic         light_o
);
  logic [W-1:0] seq;
  logic [W-1:0] level;

  lpwm_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .q_o    (seq)
  );

  lpwm_level_reg #(.W(W)) u_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (lvl_we_i),
    .data_i  (lvl_data_i),
    .level_o (level)
  );

  lpwm_cmp_out #(.W(W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .seq_i   (seq),
    .level_i (level),
    .light_o (light_o)
  );

  // R3
  light_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    light_o |-> $past(en_i));
endmodule

// File: tb/lfsr_light_pwm_tb.sv
module lfsr_light_pwm_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       lvl_we_i = 1'b0;
  logic [7:0] lvl_data_i = '0;
  logic       light_o;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  logic [7:0]  m_seq;
  logic [7:0]  m_lvl;
  logic        m_light;

  always #5 clk_i = ~clk_i;

  lfsr_light_pwm dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .lvl_we_i   (lvl_we_i),
    .lvl_data_i (lvl_data_i),
    .light_o    (light_o)
  );

  function automatic logic [7:0] seq_next(input logic [7:0] q);
    if (q == 8'h00) return 8'h01;
    return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: drive, update model at edge, compare at negedge
  task automatic tick(input logic en, input logic we, input logic [7:0] d,
                      input string tag);
    en_i = en; lvl_we_i = we; lvl_data_i = d;
    @(posedge clk_i);
    m_light = en && (m_seq < m_lvl);
    m_seq   = seq_next(m_seq);
    if (we) m_lvl = d;
    @(negedge clk_i);
    check(tag, int'(light_o), int'(m_light));
  endtask

  task automatic window(input logic [7:0] lvl, input int exp, input string tag);
    int n = 0;
    tick(1'b1, 1'b1, lvl, "R9");
    tick(1'b1, 1'b0, 8'h00, "R3");
    for (int i = 0; i < 255; i++) begin
      tick(1'b1, 1'b0, 8'h00, "R3");
      n += int'(light_o);
    end
    check(tag, n, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_seq = 8'h01; m_lvl = 8'h00; m_light = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R3 reset", int'(light_o), 0);
    rst_ni = 1'b1;

    // R1 sequence tracked by model from seed 01
    tick(1'b1, 1'b1, 8'd3, "R9");
    for (int i = 0; i < 300; i++) tick(1'b1, 1'b0, 8'h00, "R1");

    // R4 and R2: level 1 dark only if sequence never reaches 0
    window(8'd0, 0, "R4 level0");
    window(8'd1, 0, "R4 R2 level1");
    window(8'd2, 1, "R5 level2");
    window(8'd255, 254, "R6 level255");

    // R7 sweep
    for (int l = 1; l < 256; l++) window(8'(l), l - 1, "R7 sweep");

    // R8 dark while disabled, sequence keeps running, write still lands
    begin
      int n = 0;
      tick(1'b1, 1'b1, 8'd200, "R9");
      for (int i = 0; i < 300; i++) begin
        tick(1'b0, (i == 100), 8'd128, "R8");
        n += int'(light_o);
      end
      check("R8 dark count", n, 0);
      for (int i = 0; i < 300; i++) tick(1'b1, 1'b0, 8'h00, "R8 resume");
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic en = ($urandom % 4) != 0;
      logic we = ($urandom % 16) == 0;
      logic [7:0] d = 8'($urandom);
      if ($urandom % 8 == 0) d = ($urandom % 2) ? 8'hFF : 8'($urandom % 3);
      tick(en, we, d, "R3 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule